// File: doc/BRIEF.md
# Cross-VP Ring Transfer Network

This block moves one value per hop from each virtual processor (VP) to the VP with the next higher number, around a one-way ring. VP `i` sits on lane `i mod L`, so a hop from VP `i` leaves lane `i mod L` and arrives at lane `(i+1) mod L`. Each lane has one send stream and one receive stream. Each lane keeps a count of which VP it is serving. A send or receive therefore always lands on the right neighbour, and no tag travels with the data. Between each pair of adjacent lanes sits a small FIFO, so a producer can run ahead of its consumer.

The two ends of the chain do not close on themselves. They meet at a shared start/stop queue that the control processor reaches through a push stream and a pop stream. The control processor pushes a seed before a loop, and VP 0 takes the queue head as its incoming value. The value sent by VP `vl-1` goes back into the same queue. There the control processor can pop it, or VP 0 can take it as the incoming value of the next execution.

All data ports use valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. A source holds valid and data steady until that edge. Back-pressure comes from a full hop FIFO or a full queue (send side), or from an empty one (receive side). `vl` is a plain configuration input. It must be at least 1, and it may change only between complete executions, when every lane's VP count has returned to its own lane number.

Top module: `xring`

## Requirements
- R1: After reset every `rcv_valid` bit and `cp_pop_valid` are low and `cp_push_ready` is high.
- R2: A value sent on lane k for VP i (where i is not vl-1) arrives on lane (k+1) mod L as the incoming value of VP i+1, and the values on each hop arrive in the order they were sent.
- R3: Each hop holds up to 2 unread values. With both held, the producing lane's `snd_ready` is low and neither held value is lost or sent to the queue.
- R4: A value pushed by the control processor is delivered on lane 0 as the incoming value of VP 0.
- R5: The value sent for VP vl-1 enters the start/stop queue and does not appear on any lane's receive port; this includes vl=1, where VP 0 is also the last VP.
- R6: If the control processor does not pop the last VP's value, VP 0 receives it as its incoming value on the next execution.
- R7: The queue holds 4 values. A push to a full queue sees `cp_push_ready` low, and a pop from an empty queue sees `cp_pop_valid` low; no data is dropped.
- R8: When the ring writes the queue in the same cycle as a control-processor push, the ring wins and `cp_push_ready` is low. When lane 0 is ready to receive for VP 0, lane 0 wins the queue head and `cp_pop_valid` is low.
- R9: Lane k serves VPs k, k+L, k+2L, … below vl in turn, then returns to VP k; this holds when vl is not a multiple of L.
- R10: Values leave the queue in the order they entered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vl | input | 8 | Active vector length, 1 or more |
| snd_valid | input | L | Per lane: outgoing value present |
| snd_ready | output | L | Per lane: outgoing value accepted |
| snd_data | input | L×W | Per lane outgoing value |
| rcv_ready | input | L | Per lane: lane takes its incoming value |
| rcv_valid | output | L | Per lane: incoming value present |
| rcv_data | output | L×W | Per lane incoming value |
| cp_push_valid | input | 1 | Control processor push request |
| cp_push_ready | output | 1 | Queue accepts the push |
| cp_push_data | input | W | Value to push |
| cp_pop_valid | output | 1 | Queue head available to control processor |
| cp_pop_ready | input | 1 | Control processor takes the head |
| cp_pop_data | output | W | Queue head value |

## Verification
The bench builds the block with its defaults: L=4 lanes, W=32, 2-entry hops and a 4-entry queue. It changes `vl` at run time between 8, 6 and 1. With vl=8, every lane serves two VPs and a hop can be filled to the stall point. With vl=6, lanes 0 and 1 wrap after two VPs while lanes 2 and 3 serve one, and the last VP sits on lane 1. With vl=1, lane 0 both reads and writes the queue, which lets the two priority rules be seen in a single cycle.

// File: rtl/xring_pkg.sv
package xring_pkg;
  localparam int unsigned VPW = 8;
  typedef logic [VPW-1:0] vp_idx_t;

  // Next VP served by a lane: step by the lane stride, fall back home past vl.
  function automatic vp_idx_t vp_step(vp_idx_t cur, vp_idx_t stride,
                                      vp_idx_t home, vp_idx_t vl);
    logic [VPW:0] nxt;
    nxt = {1'b0, cur} + {1'b0, stride};
    if (nxt >= {1'b0, vl}) return home;
    return nxt[VPW-1:0];
  endfunction
endpackage

// File: rtl/xring_fifo.sv
module xring_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [DEPTH-1:0][W-1:0] mem;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end
endmodule

// File: rtl/xring_lane.sv
module xring_lane
  import xring_pkg::*;
#(
  parameter int unsigned LANE = 0,
  parameter int unsigned L    = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  vp_idx_t vl,
  // send side
  input  logic    snd_valid,
  output logic    snd_ready,
  output logic    hop_req,
  output logic    q_req,
  input  logic    hop_can_take,
  input  logic    q_can_take,
  // receive side
  input  logic    rcv_ready,
  output logic    rcv_pick_q,
  output logic    hop_take,
  output logic    q_take,
  input  logic    hop_has,
  input  logic    q_has,
  output logic    rcv_valid
);
  localparam vp_idx_t HOME   = vp_idx_t'(LANE);
  localparam vp_idx_t STRIDE = vp_idx_t'(L);

  vp_idx_t snd_vp, rcv_vp;
  logic    snd_last, rcv_first;

  assign snd_last  = (snd_vp == vl - vp_idx_t'(1));
  assign rcv_first = (rcv_vp == '0);

  assign snd_ready = snd_last ? q_can_take : hop_can_take;
  assign hop_req   = snd_valid && !snd_last;
  assign q_req     = snd_valid && snd_last;

  assign rcv_pick_q = rcv_first;
  assign rcv_valid  = rcv_first ? q_has : hop_has;
  assign hop_take   = rcv_ready && !rcv_first;
  assign q_take     = rcv_ready && rcv_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snd_vp <= HOME;
      rcv_vp <= HOME;
    end else begin
      if (snd_valid && snd_ready) snd_vp <= vp_step(snd_vp, STRIDE, HOME, vl);
      if (rcv_ready && rcv_valid) rcv_vp <= vp_step(rcv_vp, STRIDE, HOME, vl);
    end
  end
endmodule

// File: rtl/xring.sv
module xring
  import xring_pkg::*;
#(
  parameter int unsigned L         = 4,
  parameter int unsigned W         = 32,
  parameter int unsigned HOP_DEPTH = 2,
  parameter int unsigned Q_DEPTH   = 4,
  localparam int unsigned HCW      = $clog2(HOP_DEPTH + 1),
  localparam int unsigned QCW      = $clog2(Q_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VPW-1:0]      vl,
  input  logic [L-1:0]        snd_valid,
  output logic [L-1:0]        snd_ready,
  input  logic [L-1:0][W-1:0] snd_data,
  input  logic [L-1:0]        rcv_ready,
  output logic [L-1:0]        rcv_valid,
  output logic [L-1:0][W-1:0] rcv_data,
  input  logic                cp_push_valid,
  output logic                cp_push_ready,
  input  logic [W-1:0]        cp_push_data,
  output logic                cp_pop_valid,
  input  logic                cp_pop_ready,
  output logic [W-1:0]        cp_pop_data
);
  logic [L-1:0]          hop_req, hop_in_ready, hop_out_valid, hop_take;
  logic [L-1:0][W-1:0]   hop_head;
  logic [L-1:0][HCW-1:0] hop_cnt;
  logic [L-1:0]          q_req, q_take, pick_q;

  logic          q_in_valid, q_in_ready, q_out_valid, q_out_ready;
  logic [W-1:0]  q_in_data, q_head, ring_q_data;
  logic [QCW-1:0] q_cnt;
  logic          ring_q_any, lane_q_take, q_push, q_pop;

  // Hop k carries lane k output to lane (k+1) mod L.
  for (genvar k = 0; k < L; k++) begin : g_lane
    localparam int unsigned PREV = (k + L - 1) % L;
    localparam int unsigned NEXT = (k + 1) % L;

    xring_fifo #(.W(W), .DEPTH(HOP_DEPTH)) u_hop (
      .clk(clk), .rst_n(rst_n),
      .in_valid(hop_req[k]), .in_ready(hop_in_ready[k]), .in_data(snd_data[k]),
      .out_valid(hop_out_valid[k]), .out_ready(hop_take[NEXT]),
      .out_data(hop_head[k]), .count(hop_cnt[k])
    );

    xring_lane #(.LANE(k), .L(L)) u_lane (
      .clk(clk), .rst_n(rst_n), .vl(vl),
      .snd_valid(snd_valid[k]), .snd_ready(snd_ready[k]),
      .hop_req(hop_req[k]), .q_req(q_req[k]),
      .hop_can_take(hop_in_ready[k]), .q_can_take(q_in_ready),
      .rcv_ready(rcv_ready[k]), .rcv_pick_q(pick_q[k]),
      .hop_take(hop_take[k]), .q_take(q_take[k]),
      .hop_has(hop_out_valid[PREV]), .q_has(q_out_valid),
      .rcv_valid(rcv_valid[k])
    );

    assign rcv_data[k] = pick_q[k] ? q_head : hop_head[PREV];
  end

  // Only the lane holding VP vl-1 can request the queue at any time.
  always_comb begin
    ring_q_data = '0;
    for (int k = 0; k < L; k++)
      if (q_req[k]) ring_q_data = ring_q_data | snd_data[k];
  end

  assign ring_q_any  = |q_req;
  assign lane_q_take = |q_take;

  // Ring writer beats control processor; VP 0 reader beats control processor.
  assign q_in_valid    = ring_q_any || cp_push_valid;
  assign q_in_data     = ring_q_any ? ring_q_data : cp_push_data;
  assign cp_push_ready = q_in_ready && !ring_q_any;

  assign q_out_ready  = lane_q_take || cp_pop_ready;
  assign cp_pop_valid = q_out_valid && !lane_q_take;
  assign cp_pop_data  = q_head;

  assign q_push = q_in_valid && q_in_ready;
  assign q_pop  = q_out_valid && q_out_ready;

  xring_fifo #(.W(W), .DEPTH(Q_DEPTH)) u_ssq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(q_in_valid), .in_ready(q_in_ready), .in_data(q_in_data),
    .out_valid(q_out_valid), .out_ready(q_out_ready), .out_data(q_head),
    .count(q_cnt)
  );
endmodule

// File: rtl/xring_chk.sv
module xring_chk #(
  parameter int unsigned L         = 4,
  parameter int unsigned HOP_DEPTH = 2,
  parameter int unsigned Q_DEPTH   = 4,
  localparam int unsigned HCW      = $clog2(HOP_DEPTH + 1),
  localparam int unsigned QCW      = $clog2(Q_DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [L-1:0][HCW-1:0] hop_cnt,
  input logic [QCW-1:0]        q_cnt,
  input logic [L-1:0]          q_req,
  input logic                  q_push,
  input logic                  q_pop,
  input logic                  cp_push_ready,
  input logic                  cp_pop_valid
);
  p_q_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QCW'(Q_DEPTH));

  p_push_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == QCW'(Q_DEPTH)) |-> !cp_push_ready);

  p_pop_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == '0) |-> !cp_pop_valid);

  p_ring_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_req) |-> !cp_push_ready);

  p_one_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_req));

  p_q_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && !q_pop) |=> (q_cnt == $past(q_cnt) + QCW'(1)));

  for (genvar k = 0; k < L; k++) begin : g_hop
    p_hop_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hop_cnt[k] <= HCW'(HOP_DEPTH));
  end
endmodule

bind xring xring_chk #(.L(L), .HOP_DEPTH(HOP_DEPTH), .Q_DEPTH(Q_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hop_cnt(hop_cnt), .q_cnt(q_cnt), .q_req(q_req),
  .q_push(q_push), .q_pop(q_pop), .cp_push_ready(cp_push_ready),
  .cp_pop_valid(cp_pop_valid)
);

// File: tb/xring_bench.sv
module xring_bench;
  localparam int L = 4;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] vl = 8'd8;
  logic [L-1:0] snd_valid = '0, snd_ready, rcv_ready = '0, rcv_valid;
  logic [L-1:0][W-1:0] snd_data = '0, rcv_data;
  logic cp_push_valid = 1'b0, cp_push_ready, cp_pop_valid, cp_pop_ready = 1'b0;
  logic [W-1:0] cp_push_data = '0, cp_pop_data;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  xring #(.L(L), .W(W)) u_xring (
    .clk(clk), .rst_n(rst_n), .vl(vl),
    .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_data(snd_data),
    .rcv_ready(rcv_ready), .rcv_valid(rcv_valid), .rcv_data(rcv_data),
    .cp_push_valid(cp_push_valid), .cp_push_ready(cp_push_ready),
    .cp_push_data(cp_push_data), .cp_pop_valid(cp_pop_valid),
    .cp_pop_ready(cp_pop_ready), .cp_pop_data(cp_pop_data)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      summary();
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lane_send(int ln, logic [W-1:0] d);
    @(negedge clk); snd_valid[ln] = 1'b1; snd_data[ln] = d; #1;
    while (!snd_ready[ln]) begin @(negedge clk); #1; end
    @(posedge clk); #1; snd_valid[ln] = 1'b0;
  endtask

  task automatic lane_recv(int ln, logic [W-1:0] exp, string req);
    @(negedge clk); rcv_ready[ln] = 1'b1; #1;
    while (!rcv_valid[ln]) begin @(negedge clk); #1; end
    chk(req, rcv_data[ln], exp);
    @(posedge clk); #1; rcv_ready[ln] = 1'b0;
  endtask

  task automatic cp_push(logic [W-1:0] d);
    @(negedge clk); cp_push_valid = 1'b1; cp_push_data = d; #1;
    while (!cp_push_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; cp_push_valid = 1'b0;
  endtask

  task automatic cp_pop(logic [W-1:0] exp, string req);
    @(negedge clk); cp_pop_ready = 1'b1; #1;
    while (!cp_pop_valid) begin @(negedge clk); #1; end
    chk(req, cp_pop_data, exp);
    @(posedge clk); #1; cp_pop_ready = 1'b0;
  endtask

  // One execution: each VP adds 1 to what it receives.
  task automatic run_exec(int n, logic [W-1:0] first, string req0, string reqn);
    for (int i = 0; i < n; i++) begin
      lane_recv(i % L, first + W'(i), (i == 0) ? req0 : reqn);
      lane_send(i % L, first + W'(i + 1));
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 rcv_valid", W'(rcv_valid), '0);
    chk("R1 cp_pop_valid", W'(cp_pop_valid), '0);
    chk("R1 cp_push_ready", W'(cp_push_ready), 1);
  endtask

  task automatic t_chain();
    vl = 8'd8;
    cp_push(32'd100);
    run_exec(8, 32'd100, "R4", "R2");
    cp_pop(32'd108, "R5");
  endtask

  task automatic t_keep();
    vl = 8'd8;
    cp_push(32'd300);
    run_exec(8, 32'd300, "R4", "R2");
    @(negedge clk); #1;
    chk("R6 value held", W'(cp_pop_valid), 1);
    run_exec(8, 32'd308, "R6", "R2");
    cp_pop(32'd316, "R6");
  endtask

  task automatic t_wrap();
    vl = 8'd6;
    cp_push(32'd200);
    run_exec(6, 32'd200, "R4", "R9");
    @(negedge clk); #1;
    chk("R5 no hop out of last VP", W'(rcv_valid[2]), '0);
    chk("R5 last VP to queue", W'(cp_pop_valid), 1);
    cp_pop(32'd206, "R9");
  endtask

  task automatic t_hop_fill();
    vl = 8'd8;
    lane_send(0, 32'h11);
    lane_send(0, 32'h22);
    @(negedge clk); #1;
    chk("R3 stall when hop full", W'(snd_ready[0]), '0);
    chk("R3 nothing to queue", W'(cp_pop_valid), '0);
    chk("R3 value waiting", W'(rcv_valid[1]), 1);
    lane_recv(1, 32'h11, "R2");
    lane_recv(1, 32'h22, "R3");
  endtask

  task automatic t_qfull();
    vl = 8'd8;
    for (int i = 0; i < 4; i++) cp_push(32'hA0 + W'(i));
    @(negedge clk); cp_push_valid = 1'b1; cp_push_data = 32'hA4; #1;
    chk("R7 full stalls push", W'(cp_push_ready), '0);
    @(negedge clk); #1;
    chk("R7 still stalled", W'(cp_push_ready), '0);
    cp_push_valid = 1'b0;
    for (int i = 0; i < 4; i++) cp_pop(32'hA0 + W'(i), "R10");
    @(negedge clk); #1;
    chk("R7 empty pop", W'(cp_pop_valid), '0);
  endtask

  task automatic t_prio();
    vl = 8'd1;
    @(negedge clk);
    snd_valid[0] = 1'b1; snd_data[0] = 32'h55;
    cp_push_valid = 1'b1; cp_push_data = 32'h66; #1;
    chk("R8 cp push blocked", W'(cp_push_ready), '0);
    chk("R5 vl=1 send accepted", W'(snd_ready[0]), 1);
    @(posedge clk); #1; snd_valid[0] = 1'b0;
    @(negedge clk); #1;
    chk("R8 cp push resumes", W'(cp_push_ready), 1);
    @(posedge clk); #1; cp_push_valid = 1'b0;
    @(negedge clk); rcv_ready[0] = 1'b1; cp_pop_ready = 1'b1; #1;
    chk("R8 cp pop blocked", W'(cp_pop_valid), '0);
    chk("R8 VP0 gets head", rcv_data[0], 32'h55);
    @(posedge clk); #1; rcv_ready[0] = 1'b0;
    @(negedge clk); #1;
    chk("R10 second entry", cp_pop_data, 32'h66);
    chk("R8 cp pop resumes", W'(cp_pop_valid), 1);
    @(posedge clk); #1; cp_pop_ready = 1'b0;
    @(negedge clk); #1;
    chk("R7 drained", W'(cp_pop_valid), '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_chain();
    t_keep();
    t_wrap();
    t_hop_fill();
    t_qfull();
    t_prio();
    summary();
  end
endmodule